// File: doc/BRIEF.md
# Single-Wire Startup Mode Detector

This controller watches one control pin and decides, each time the device leaves shutdown, whether it runs in duty-cycle reference mode or in single-wire serial programming mode. A rising edge on the pin while in shutdown enables the device and opens a detection window. A low interval of the required length, placed after an initial blanking delay and completed inside that window, selects serial mode at once. If no such low occurs, the device falls back to duty-cycle mode when the window closes.

The chosen mode then stays locked. Only a long continuous low, which is the shutdown condition, clears it. Short lows do not shut the device down, so serial data bits and duty-cycle pulses can toggle the pin freely. All durations are parameters counted in clock cycles. The pin passes through a synchronizer before edge detection. The default reference code that follows serial-mode entry belongs to the downstream data decoder.

Top module: `startup_mode_detect`

## Requirements
- R1: While rst_ni is low, and after it is released with the pin low, en_o, serial_o, mode_latch_o and shdn_o are all 0.
- R2: A rising edge on ctrl_i while in shutdown sets en_o on the third rising clock edge after the pin is driven high: two synchronizer edges, then the state register.
- R3: During the first DLY_CYC cycles of the window, counted from the cycle after enable, a low level does not count toward serial detection.
- R4: Serial mode needs DET_CYC consecutive low cycles, all at window index DLY_CYC or later. A run of DET_CYC-1 such cycles gives duty-cycle mode.
- R5: serial_o and a mode_latch_o pulse appear on the clock edge right after the last qualifying low cycle, without waiting for the window to end.
- R6: A qualifying low must finish by window index WIN_CYC-1. Otherwise the device enters duty-cycle mode (serial_o = 0), with a mode_latch_o pulse on the edge after index WIN_CYC-1.
- R7: Once a mode is latched, no pin pattern changes serial_o until shutdown. This includes a low that would have qualified during detection.
- R8: In either mode, SHDN_CYC consecutive low cycles, counted from the mode latch, return the device to shutdown. en_o and serial_o clear, and shdn_o pulses. SHDN_CYC-1 low cycles have no effect.
- R9: After shutdown, the next rising edge starts a fresh detection, and the previous mode is forgotten.
- R10: mode_latch_o and shdn_o are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock that all durations are counted in |
| rst_ni | input | 1 | Asynchronous active-low reset, forces shutdown |
| ctrl_i | input | 1 | Asynchronous control pin |
| en_o | output | 1 | Device enabled (not in shutdown) |
| serial_o | output | 1 | 1 = serial programming mode latched, 0 = duty-cycle mode or not yet decided |
| mode_latch_o | output | 1 | One-cycle pulse when the mode is latched |
| shdn_o | output | 1 | One-cycle pulse on entry to shutdown |

## Verification
The bench builds the block with a 2-stage synchronizer, a 4-cycle blanking delay, a 6-cycle qualifying low, a 20-cycle window and a 12-cycle shutdown low. With these values, every timing boundary falls within a few dozen cycles: a low starting one cycle inside the blanking delay, a run one cycle short, a run ending on the last window cycle against one ending a cycle late, and shutdown lows of 11 and 12 cycles. The bench can therefore hit each boundary at its exact clock edge.

// File: rtl/swmd_pkg.sv
`timescale 1ns/1ps
package swmd_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_DETECT = 2'd1,
    ST_PWM    = 2'd2,
    ST_SERIAL = 2'd3
  } swmd_state_e;
endpackage

// File: rtl/swmd_sync.sv
`timescale 1ns/1ps
module swmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic rise_o
);
  logic sr_q [STAGES];
  logic prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q[0] <= 1'b0;
        else         sr_q[0] <= pin_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q[g] <= 1'b0;
        else         sr_q[g] <= sr_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sr_q[STAGES-1];

  assign level_o = sr_q[STAGES-1];
  assign rise_o  = sr_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/swmd_cnt.sv
`timescale 1ns/1ps
module swmd_cnt #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] CntMax = '1;
  logic [WIDTH-1:0] cnt_q;

  // clear wins over increment; saturates instead of wrapping
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;

  assign cnt_o = cnt_q;
endmodule

// File: rtl/startup_mode_detect.sv
`timescale 1ns/1ps
module startup_mode_detect #(
  parameter int SYNC_STAGES = 2,
  parameter int DLY_CYC     = 10000,
  parameter int DET_CYC     = 26000,
  parameter int WIN_CYC     = 100000,
  parameter int SHDN_CYC    = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_i,
  output logic en_o,
  output logic serial_o,
  output logic mode_latch_o,
  output logic shdn_o
);
  import swmd_pkg::*;

  localparam int LowMax = (DET_CYC > SHDN_CYC) ? DET_CYC : SHDN_CYC;
  localparam int WinW   = $clog2(WIN_CYC + 1);
  localparam int LowW   = $clog2(LowMax + 1);
  localparam logic [WinW-1:0] WinDly  = WinW'(DLY_CYC);
  localparam logic [WinW-1:0] WinLast = WinW'(WIN_CYC - 1);
  localparam logic [LowW-1:0] DetLast = LowW'(DET_CYC - 1);
  localparam logic [LowW-1:0] OffLast = LowW'(SHDN_CYC - 1);

  swmd_state_e state_q, state_d;
  logic level, rise, pin_low, blank_over;
  logic win_clr, win_inc, low_clr, low_inc;
  logic latch_d, latch_q, shdn_d, shdn_q;
  logic [WinW-1:0] win_cnt;
  logic [LowW-1:0] low_cnt;

  swmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ctrl_i),
    .level_o(level),
    .rise_o (rise)
  );

  swmd_cnt #(.WIDTH(WinW)) u_win_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (win_clr),
    .inc_i (win_inc),
    .cnt_o (win_cnt)
  );

  swmd_cnt #(.WIDTH(LowW)) u_low_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (low_clr),
    .inc_i (low_inc),
    .cnt_o (low_cnt)
  );

  assign pin_low    = ~level;
  assign blank_over = (win_cnt >= WinDly);

  always_comb begin
    state_d = state_q;
    win_clr = 1'b0;
    win_inc = 1'b0;
    low_clr = 1'b0;
    low_inc = 1'b0;
    latch_d = 1'b0;
    shdn_d  = 1'b0;
    unique case (state_q)
      ST_OFF: begin
        win_clr = 1'b1;
        low_clr = 1'b1;
        if (rise) state_d = ST_DETECT;
      end
      ST_DETECT: begin
        win_inc = 1'b1;
        low_inc = 1'b1;
        low_clr = ~(pin_low & blank_over);   // lows inside blanking never count
        if (pin_low && blank_over && low_cnt == DetLast) begin
          state_d = ST_SERIAL;
          latch_d = 1'b1;
          low_clr = 1'b1;
        end else if (win_cnt == WinLast) begin
          state_d = ST_PWM;
          latch_d = 1'b1;
          low_clr = 1'b1;
        end
      end
      ST_PWM, ST_SERIAL: begin
        low_inc = 1'b1;
        low_clr = ~pin_low;
        if (pin_low && low_cnt == OffLast) begin
          state_d = ST_OFF;
          shdn_d  = 1'b1;
        end
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      state_q <= ST_OFF;
      latch_q <= 1'b0;
      shdn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      latch_q <= latch_d;
      shdn_q  <= shdn_d;
    end

  assign en_o         = (state_q != ST_OFF);
  assign serial_o     = (state_q == ST_SERIAL);
  assign mode_latch_o = latch_q;
  assign shdn_o       = shdn_q;
endmodule

// File: rtl/swmd_checker.sv
`timescale 1ns/1ps
module swmd_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic serial_i,
  input logic latch_i,
  input logic shdn_i
);
  assert_latch_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> !latch_i);
  assert_shdn_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |=> !shdn_i);
  assert_serial_on_latch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(serial_i) |-> latch_i);
  assert_serial_needs_en_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serial_i |-> en_i);
  assert_mode_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i)) |-> ($stable(serial_i) || latch_i));
  assert_shdn_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shdn_i |-> (!en_i && !serial_i && $past(en_i)));
  assert_enable_fresh_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> (!serial_i && !latch_i));
  assert_latch_enabled_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |-> (en_i && $past(en_i)));
endmodule

bind startup_mode_detect swmd_checker u_swmd_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_o),
  .serial_i(serial_o),
  .latch_i (mode_latch_o),
  .shdn_i  (shdn_o)
);

// File: tb/startup_mode_detect_test.sv
`timescale 1ns/1ps
module startup_mode_detect_test;
  localparam int DLY  = 4;
  localparam int DET  = 6;
  localparam int WIN  = 20;
  localparam int SHDN = 12;
  localparam int NVEC = 7;
  // {high cycles before low, low cycles, expected serial}
  localparam int VEC [NVEC][3] = '{
    '{5, 6, 1},    // R4 minimum qualifying low right after blanking
    '{4, 6, 0},    // R3 first low cycle inside blanking
    '{5, 5, 0},    // R4 one cycle short
    '{15, 6, 1},   // R6 ends on last window cycle
    '{16, 6, 0},   // R6 ends one cycle late
    '{30, 0, 0},   // R6 steady high
    '{8, 11, 1}    // R8 low run restarts at latch, no shutdown
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic ctrl_i = 1'b0;
  logic en_o, serial_o, mode_latch_o, shdn_o;
  int tests = 0, fails = 0;
  int latch_cnt = 0, shdn_cnt = 0;

  always #2.5 clk_i = ~clk_i;

  startup_mode_detect #(
    .SYNC_STAGES(2), .DLY_CYC(DLY), .DET_CYC(DET), .WIN_CYC(WIN), .SHDN_CYC(SHDN)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_i(ctrl_i),
    .en_o(en_o), .serial_o(serial_o), .mode_latch_o(mode_latch_o), .shdn_o(shdn_o)
  );

  always @(posedge clk_i) begin
    if (mode_latch_o) latch_cnt <= latch_cnt + 1;
    if (shdn_o)       shdn_cnt  <= shdn_cnt + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_low(input int n);
    ctrl_i = 1'b0;
    tick(n);
    ctrl_i = 1'b1;
  endtask

  initial begin
    #1_000_000;
    tests++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int l0, s0;
    // R1 reset state
    tick(3);
    chk("R1 en in reset", en_o, 0);
    chk("R1 serial in reset", serial_o, 0);
    rst_ni = 1'b1;
    tick(4);
    chk("R1 en after reset", en_o, 0);
    chk("R1 pulses after reset", mode_latch_o | shdn_o, 0);

    // R2 enable latency, R6 window end exact edge
    ctrl_i = 1'b1;
    tick(2);
    chk("R2 en before third edge", en_o, 0);
    tick(1);
    chk("R2 en on third edge", en_o, 1);
    tick(19);
    chk("R6 no latch before window end", mode_latch_o, 0);
    tick(1);
    chk("R6 latch at window end", mode_latch_o, 1);
    chk("R6 pwm chosen", serial_o, 0);
    tick(1);
    chk("R10 latch one cycle", mode_latch_o, 0);

    // R7 qualifying-length low in pwm keeps mode
    tick(3);
    pulse_low(DET);
    tick(10);
    chk("R7 pwm locked", serial_o, 0);
    chk("R7 still enabled", en_o, 1);

    // R8 shutdown boundaries
    pulse_low(SHDN - 1);
    tick(5);
    chk("R8 short low keeps enable", en_o, 1);
    ctrl_i = 1'b0;
    tick(13);
    chk("R8 en before shutdown edge", en_o, 1);
    tick(1);
    chk("R8 shutdown", en_o, 0);
    chk("R8 shdn pulse", shdn_o, 1);
    tick(1);
    chk("R10 shdn one cycle", shdn_o, 0);
    tick(5);

    // R5 serial entry exact edge
    ctrl_i = 1'b1;
    tick(5);
    ctrl_i = 1'b0;
    tick(6);
    ctrl_i = 1'b1;
    tick(1);
    chk("R5 serial not yet", serial_o, 0);
    tick(1);
    chk("R5 serial immediately", serial_o, 1);
    chk("R5 latch pulse", mode_latch_o, 1);
    tick(1);
    chk("R10 latch one cycle serial", mode_latch_o, 0);

    // R7 serial locked under data-like toggling and long short lows
    for (int i = 0; i < 3; i++) begin
      pulse_low(5);
      tick(3);
    end
    pulse_low(SHDN - 1);
    tick(30);
    chk("R7 serial locked", serial_o, 1);
    chk("R7 serial enabled", en_o, 1);

    // R9 shutdown then restart forgets serial
    ctrl_i = 1'b0;
    tick(SHDN + 5);
    chk("R8 serial cleared", serial_o, 0);
    ctrl_i = 1'b1;
    tick(40);
    chk("R9 restart enabled", en_o, 1);
    chk("R9 restart defaults pwm", serial_o, 0);
    ctrl_i = 1'b0;
    tick(SHDN + 5);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      l0 = latch_cnt;
      s0 = shdn_cnt;
      ctrl_i = 1'b1;
      tick(VEC[v][0]);
      if (VEC[v][1] > 0) pulse_low(VEC[v][1]);
      tick(40);
      chk($sformatf("R4/R6 vec%0d enabled", v), en_o, 1);
      chk($sformatf("R3/R4/R6 vec%0d mode", v), serial_o, VEC[v][2]);
      chk($sformatf("R10 vec%0d one latch", v), latch_cnt - l0, 1);
      ctrl_i = 1'b0;
      tick(SHDN + 5);
      chk($sformatf("R8 vec%0d shutdown", v), en_o, 0);
      chk($sformatf("R8 vec%0d shdn count", v), shdn_cnt - s0, 1);
    end

    // R1 reset mid-run forces shutdown
    ctrl_i = 1'b1;
    tick(10);
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset clears en", en_o, 0);
    tick(2);
    rst_ni = 1'b1;
    ctrl_i = 1'b0;
    tick(3);
    chk("R1 off after reset", en_o, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule